// File: doc/BRIEF.md
# DDR Burst-of-Two Synchronous SRAM Core

This block is a synthesizable model of a small synchronous SRAM whose data path runs at double data rate and moves two words per access. Commands are taken on the rising edge of the main clock. Write data enters on the rising edge one cycle later and on the falling edge that follows it. Read data comes back on both clock phases. The block has one clock, and its falling edge stands in for the rising edge of the complementary clock.

A command carries a word address. The first word of the pair always belongs to that address. The second word belongs to the same address with bit 0 inverted, so an odd start address runs the pair in descending order. Each 9-bit lane of each word has its own active-low write enable, which allows partial updates within either half of the burst. A new command may be issued on every cycle, in any mix of reads and writes. A read placed directly after a write to the same pair returns the new contents.

Top module: `ddr_burst_sram`

## Requirements
- R1: While reset is low and after it is released, `rdValid` and `rdOe` are 0, and every word of the array reads back as zero until it is written.
- R2: When `loadN` is 1 on a rising edge, that cycle causes no write and no read, whatever `rdWrSel`, `addr`, `wrData` and `byteWeN` carry.
- R3: A write command is `loadN`=0 with `rdWrSel`=0. The address is sampled with the command, and the word on `wrData` at the next rising edge is stored at that address.
- R4: The word on `wrData` at the falling edge after that rising edge is stored at the command address with bit 0 inverted.
- R5: `byteWeN[i]` is active low and guards bits `9*i+8 : 9*i`. It is sampled separately with each of the two write words. A lane whose enable is 1 keeps its old contents.
- R6: A read command is `loadN`=0 with `rdWrSel`=1. For a command sampled at rising edge t, the word at the command address drives `rdData` from the falling edge 1.5 cycles after t, and the partner word (bit 0 inverted) drives it from the rising edge 2 cycles after t.
- R7: `rdValid` and `rdOe` are 1 during exactly the two half-cycles that carry read data, and 0 at all other times.
- R8: Commands may be issued on consecutive cycles in any mix. Back-to-back reads give an unbroken stream of valid words, and every burst holds its own data.
- R9: A read issued on the cycle right after a write to the same pair returns the newly written data.
- R10: Bit 0 of the address selects the burst order. A read or write at an odd address handles the odd word first and the even word second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; the falling edge acts as the complementary clock edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loadN | input | 1 | Active-low command strobe |
| rdWrSel | input | 1 | 1 = read, 0 = write, when `loadN` is 0 |
| addr | input | ADDR_W (7) | Word address; bit 0 is the first word of the burst |
| wrData | input | DATA_W (36) | Write data, sampled on both edges in the data phase |
| byteWeN | input | LANES (4) | Active-low per-lane write enables, one per 9 bits |
| rdData | output | DATA_W (36) | Read data, one word per clock phase |
| rdOe | output | 1 | Output enable for the shared data bus |
| rdValid | output | 1 | Marks each half-cycle that carries a read word |

## Verification
Most faults in the control stage change timing, and they show at the ports within two cycles of the command. A lost read strobe or a misaligned read strobe moves `rdValid` off its 1.5-cycle slot. A wrongly latched address returns a word from the wrong pair at the first checked half-cycle. A corrupted write path behaves differently: a bad lane enable, a swapped word order or a commit on the wrong edge stays hidden in the array until that location is read. For this reason the bench reads back locations soon after writing them, including on the very next cycle, and compares each returned half-word against a lane-level model.

// File: rtl/ddr_sram_pkg.sv
package ddr_sram_pkg;

  // Strobes passed from the command pipeline to the storage datapath
  typedef struct packed {
    logic wrCapture;  // capture first write word on this rising edge
    logic wrCommit;   // commit both write words on the coming falling edge
    logic rdFetch;    // fetch both read words on the coming falling edge
  } sram_strobe_t;

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import ddr_sram_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadN,
  input  logic              rdWrSel,
  input  logic [ADDR_W-1:0] addr,
  output sram_strobe_t      strb,
  output logic [ADDR_W-1:0] stageAddr
);

  logic              wrPhase;
  logic              rdPhase;
  logic              wrCommit;
  logic              rdFetch;
  logic [ADDR_W-1:0] cmdAddr;

  // Stage 1: command sampled. Stage 2: data phase / fetch issued.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPhase   <= 1'b0;
      rdPhase   <= 1'b0;
      wrCommit  <= 1'b0;
      rdFetch   <= 1'b0;
      cmdAddr   <= '0;
      stageAddr <= '0;
    end else begin
      wrPhase  <= !loadN && !rdWrSel;
      rdPhase  <= !loadN && rdWrSel;
      if (!loadN) cmdAddr <= addr;
      wrCommit  <= wrPhase;
      rdFetch   <= rdPhase;
      stageAddr <= cmdAddr;
    end
  end

  always_comb begin
    strb.wrCapture = wrPhase;
    strb.wrCommit  = wrCommit;
    strb.rdFetch   = rdFetch;
  end

  // R3: a write command reaches the commit stage two edges later with its address
  a_r3_write_reaches_commit: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN && !rdWrSel) |=> ##1 (strb.wrCommit && stageAddr == $past(addr, 2)));

  // R6: a read command reaches the fetch stage two edges later with its address
  a_r6_read_reaches_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN && rdWrSel) |=> ##1 (strb.rdFetch && stageAddr == $past(addr, 2)));

  // R2: a deselected cycle never produces a commit or a fetch
  a_r2_deselect_idle: assert property (@(posedge clk) disable iff (!rstN)
    loadN |=> ##1 (!strb.wrCommit && !strb.rdFetch));

  // R8: a stage never holds a read and a write at once
  a_r8_single_op_per_stage: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrPhase, rdPhase}) && $onehot0({wrCommit, rdFetch}));

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import ddr_sram_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 7,
  localparam int LANES = DATA_W / LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sram_strobe_t      strb,
  input  logic [ADDR_W-1:0] stageAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  byteWeN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] word0Q;
  logic [LANES-1:0]  lane0Q;
  logic [DATA_W-1:0] dataNeg;
  logic [DATA_W-1:0] holdQ;
  logic [DATA_W-1:0] dataPos;
  logic              validNeg;
  logic              validPos;
  logic [ADDR_W-1:0] partnerAddr;

  assign partnerAddr = {stageAddr[ADDR_W-1:1], ~stageAddr[0]};

  // Rising-edge side: first write word, second read word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word0Q   <= '0;
      lane0Q   <= '1;
      dataPos  <= '0;
      validPos <= 1'b0;
    end else begin
      if (strb.wrCapture) begin
        word0Q <= wrData;
        lane0Q <= byteWeN;
      end
      dataPos  <= holdQ;
      validPos <= validNeg;
    end
  end

  // Falling-edge side: array commit and read fetch
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
      dataNeg  <= '0;
      holdQ    <= '0;
      validNeg <= 1'b0;
    end else begin
      if (strb.wrCommit) begin
        for (int i = 0; i < LANES; i++) begin
          if (!lane0Q[i])  mem[stageAddr][i*LANE_W +: LANE_W]   <= word0Q[i*LANE_W +: LANE_W];
          if (!byteWeN[i]) mem[partnerAddr][i*LANE_W +: LANE_W] <= wrData[i*LANE_W +: LANE_W];
        end
      end
      validNeg <= strb.rdFetch;
      if (strb.rdFetch) begin
        dataNeg <= mem[stageAddr];
        holdQ   <= mem[partnerAddr];
      end
    end
  end

  // Phase mux: low phase shows the first word, high phase the second
  assign rdData  = clk ? dataPos : dataNeg;
  assign rdValid = clk ? validPos : validNeg;

endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram
  import ddr_sram_pkg::*;
#(
  parameter  int DATA_W = 36,
  parameter  int LANE_W = 9,
  parameter  int PAIRS  = 64,
  localparam int ADDR_W = $clog2(PAIRS) + 1,
  localparam int LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadN,
  input  logic              rdWrSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  byteWeN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdOe,
  output logic              rdValid
);

  sram_strobe_t      strb;
  logic [ADDR_W-1:0] stageAddr;
  logic              wordValid;

  sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadN     (loadN),
    .rdWrSel   (rdWrSel),
    .addr      (addr),
    .strb      (strb),
    .stageAddr (stageAddr)
  );

  sram_datapath #(.DATA_W(DATA_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .stageAddr (stageAddr),
    .wrData    (wrData),
    .byteWeN   (byteWeN),
    .rdData    (rdData),
    .rdValid   (wordValid)
  );

  assign rdValid = wordValid;
  assign rdOe    = wordValid;

endmodule

// File: tb/ddr_burst_sram_tb.sv
`timescale 1ns/1ps
module ddr_burst_sram_tb;

  localparam int DW = 36;
  localparam int LW = 9;
  localparam int LN = DW / LW;
  localparam int AW = 7;
  localparam int NT = 27;

  // Entry: op[20:19] (0 nop, 1 read, 2 write, 3 nop with write fields), addr[18:12], be0[11:8], be1[7:4], tag[3:0]
  localparam logic [20:0] TABLE [NT] = '{
    {2'd1, 7'd0,  4'h0, 4'h0, 4'd1},
    {2'd2, 7'd4,  4'h0, 4'h0, 4'd0},
    {2'd1, 7'd4,  4'h0, 4'h0, 4'd9},
    {2'd2, 7'd7,  4'h0, 4'h0, 4'd0},
    {2'd0, 7'd0,  4'h0, 4'h0, 4'd0},
    {2'd1, 7'd7,  4'h0, 4'h0, 4'd10},
    {2'd1, 7'd6,  4'h0, 4'h0, 4'd4},
    {2'd2, 7'd4,  4'ha, 4'h5, 4'd0},
    {2'd0, 7'd0,  4'h0, 4'h0, 4'd0},
    {2'd1, 7'd4,  4'h0, 4'h0, 4'd5},
    {2'd2, 7'd6,  4'h0, 4'h0, 4'd0},
    {2'd3, 7'd6,  4'h0, 4'h0, 4'd0},
    {2'd3, 7'd2,  4'h0, 4'h0, 4'd0},
    {2'd0, 7'd2,  4'h0, 4'h0, 4'd0},
    {2'd1, 7'd2,  4'h0, 4'h0, 4'd2},
    {2'd1, 7'd4,  4'h0, 4'h0, 4'd6},
    {2'd1, 7'd6,  4'h0, 4'h0, 4'd6},
    {2'd1, 7'd7,  4'h0, 4'h0, 4'd8},
    {2'd0, 7'd0,  4'h0, 4'h0, 4'd0},
    {2'd0, 7'd0,  4'h0, 4'h0, 4'd0},
    {2'd2, 7'd10, 4'h0, 4'h0, 4'd0},
    {2'd2, 7'd11, 4'h3, 4'hc, 4'd0},
    {2'd0, 7'd0,  4'h0, 4'h0, 4'd0},
    {2'd1, 7'd10, 4'h0, 4'h0, 4'd3},
    {2'd1, 7'd11, 4'h0, 4'h0, 4'd8},
    {2'd0, 7'd0,  4'h0, 4'h0, 4'd0},
    {2'd0, 7'd0,  4'h0, 4'h0, 4'd0}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadN = 1'b1;
  logic          rdWrSel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [LN-1:0] byteWeN = '1;
  logic [DW-1:0] rdData;
  logic          rdOe;
  logic          rdValid;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] model [1 << AW];
  logic          wrPendV = 1'b0;
  logic [AW-1:0] wrPendA = '0;
  logic [LN-1:0] wrPendB0 = '1;
  logic [LN-1:0] wrPendB1 = '1;
  logic          rdAV = 1'b0, rdBV = 1'b0;
  logic [DW-1:0] rdA0, rdA1, rdB0, rdB1;
  string         rdATag, rdBTag;

  ddr_burst_sram u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .loadN   (loadN),
    .rdWrSel (rdWrSel),
    .addr    (addr),
    .wrData  (wrData),
    .byteWeN (byteWeN),
    .rdData  (rdData),
    .rdOe    (rdOe),
    .rdValid (rdValid)
  );

  always #5 clk = ~clk;

  function automatic string tagName(int id);
    case (id)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] partner(logic [AW-1:0] a);
    return {a[AW-1:1], ~a[0]};
  endfunction

  task automatic applyWord(logic [AW-1:0] a, logic [LN-1:0] be, logic [DW-1:0] d);
    for (int i = 0; i < LN; i++)
      if (!be[i]) model[a][i*LW +: LW] = d[i*LW +: LW];
  endtask

  // One command cycle; entered 2.5 ns before the rising edge
  task automatic step(int op, logic [AW-1:0] a, logic [LN-1:0] b0, logic [LN-1:0] b1, string tag);
    logic [DW-1:0] d0, d1;
    // word 0 of read issued two cycles back (R6/R7)
    if (rdBV) begin
      check(rdBTag, "word0", rdData, rdB0);
      check("R7", "valid/oe word0", {34'd0, rdValid, rdOe}, 36'd3);
    end else begin
      check("R7", "idle valid/oe low phase", {34'd0, rdValid, rdOe}, 36'd0);
    end
    loadN   = !(op == 1 || op == 2);
    rdWrSel = (op == 1) ? 1'b1 : (op == 0 ? 1'b1 : 1'b0);
    addr    = a;
    d0 = DW'({$urandom(), $urandom()});
    d1 = DW'({$urandom(), $urandom()});
    wrData  = d0;
    byteWeN = wrPendV ? wrPendB0 : LN'($urandom());
    #5;
    if (rdBV) begin
      check(rdBTag, "word1", rdData, rdB1);
      check("R7", "valid/oe word1", {34'd0, rdValid, rdOe}, 36'd3);
    end else begin
      check("R7", "idle valid/oe high phase", {34'd0, rdValid, rdOe}, 36'd0);
    end
    wrData  = d1;
    byteWeN = wrPendV ? wrPendB1 : LN'($urandom());
    if (wrPendV) begin
      applyWord(wrPendA, wrPendB0, d0);
      applyWord(partner(wrPendA), wrPendB1, d1);
    end
    #5;
    rdBV = rdAV; rdB0 = rdA0; rdB1 = rdA1; rdBTag = rdATag;
    rdAV = (op == 1);
    rdA0 = model[a];
    rdA1 = model[partner(a)];
    rdATag = tag;
    wrPendV = (op == 2); wrPendA = a; wrPendB0 = b0; wrPendB1 = b1;
  endtask

  initial begin
    for (int w = 0; w < (1 << AW); w++) model[w] = '0;
    #1;
    check("R1", "valid/oe in reset", {34'd0, rdValid, rdOe}, 36'd0);
    #11 rstN = 1'b1;
    #10.5;
    for (int k = 0; k < NT; k++)
      step(int'(TABLE[k][20:19]), TABLE[k][18:12], TABLE[k][11:8], TABLE[k][7:4],
           tagName(int'(TABLE[k][3:0])));
    // random mixed traffic over a small address window (R8)
    for (int k = 0; k < 400; k++)
      step(int'($urandom() % 4), AW'($urandom() % 12), LN'($urandom()), LN'($urandom()), "R8");
    step(0, '0, '1, '1, "R8");
    step(0, '0, '1, '1, "R8");
    // reset in the middle of a read burst (R1)
    loadN = 1'b0; rdWrSel = 1'b1; addr = 7'd4;
    #5 loadN = 1'b1;
    #6 rstN = 1'b0;
    #9;
    check("R1", "valid/oe after mid-burst reset", {34'd0, rdValid, rdOe}, 36'd0);
    #1 rstN = 1'b1;
    for (int w = 0; w < (1 << AW); w++) model[w] = '0;
    rdAV = 1'b0; rdBV = 1'b0; wrPendV = 1'b0;
    #9;
    step(1, 7'd4, '1, '1, "R1");
    step(1, 7'd11, '1, '1, "R1");
    step(0, '0, '1, '1, "R1");
    step(0, '0, '1, '1, "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule